// File: doc/BRIEF.md
# Dual-Mode Device Configuration Port

This block keeps the mode settings of a multi-channel converter and turns them into the control levels the rest of the chip uses: one-lane versus two-lane output, output drive current, power-down, internal output termination, and a byte of auxiliary mode bits. A strap input picks how the four configuration pins are used. With the strap low, the pins form a four-wire serial bus with chip select, serial clock, serial data in and an open-drain serial data out. Over that bus a host writes the mode registers and reads them back. With the strap high, the same pins are plain static levels that set the four main controls directly.

All pins are brought into the system clock domain through a synchronizer of configurable depth. Serial clock edges are found by oversampling. A serial frame is 16 bits, sent MSB first: a read flag, a 7-bit register address and 8 data bits. A write takes effect only when chip select returns high after exactly 16 serial clock rising edges. The serial output pin is modelled as a pull-low enable: the block either pulls the line low or releases it.

Top module: `mode_cfg_port`

## Requirements
- R1: After a synchronous reset, all registers are zero. The outputs then show two-lane mode, the higher current, powered up, termination off and auxiliary bits 0x00, and the serial output is released (`sdo_pull_low_o` = 0).
- R2: While the strap is high, the outputs follow the pins: `one_lane_o` = CS, `low_current_o` = SCK, `power_down_o` = SDI and `term_en_o` = the SDO pad level. The serial output is never pulled low in this mode.
- R3: While the strap is low and CS is low, SDI is shifted in on each SCK rising edge. Frame bit 15 is the read flag (0 = write), bits 14:8 are the address and bits 7:0 are the data. A write commits when CS rises after exactly 16 rising edges.
- R4: A frame with any number of rising edges other than 16 changes no register.
- R5: SCK edges while CS is high are not shifted in. A correct frame that follows such edges still commits.
- R6: On a read (bit 15 = 1), the output is released during the 8 command bits. Register bit 7 is driven after the 8th rising edge and bit 0 after the 15th (low = 0, released = 1), each valid for the host at the following falling edge. The output is released afterwards and while CS is high. All 8 stored bits read back as written.
- R7: A read frame changes no register and no output.
- R8: Register map: address 0 holds the auxiliary mode byte. Address 1 bit 0 selects one-lane, bit 1 selects lower current and bit 2 enables termination. Address 2 bit 0 requests power-down. Writes to any other address are dropped, and reads of them return 0x00.
- R9: While the strap is high, serial traffic is ignored. When the strap returns low, the register values set earlier over the bus drive the outputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_par_i | input | 1 | Mode strap: 1 = static pins, 0 = serial bus |
| cs_i | input | 1 | Chip select (serial) / lane select (static) |
| sck_i | input | 1 | Serial clock (serial) / current select (static) |
| sdi_i | input | 1 | Serial data in (serial) / power-down (static) |
| sdo_pad_i | input | 1 | Level on the SDO pad, used as termination enable in static mode |
| sdo_pull_low_o | output | 1 | Open-drain enable: 1 pulls the serial output low |
| one_lane_o | output | 1 | 1 = one-lane output, 0 = two-lane |
| low_current_o | output | 1 | 1 = lower output current |
| power_down_o | output | 1 | 1 = power-down requested |
| term_en_o | output | 1 | 1 = internal termination enabled |
| aux_mode_o | output | 8 | Auxiliary mode byte from address 0 |

## Verification
The static mode is swept over all 16 combinations of the four pins, so a swapped or stuck pin-to-control mapping shows up. Serial writes sweep every combination of the three output-control bits and several auxiliary bytes with alternating and single-bit patterns. Each write is followed by a read-back, which separates shift order and bit alignment errors from decode errors. Frame lengths from 0 to 20 edges, with 16 skipped, confirm that only the exact length commits. Traffic to unmapped addresses, traffic in static mode, and stray clocks with CS high show whether any path other than a proper frame can alter state.

// File: rtl/mode_cfg_pkg.sv
package mode_cfg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 8;
    localparam int ADDR_W     = CMD_BITS - 1;
    localparam int DATA_W     = FRAME_BITS - CMD_BITS;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    localparam int NUM_REGS   = 3;
    localparam int REG_AUX    = 0;
    localparam int REG_OUT    = 1;
    localparam int REG_PWR    = 2;

    localparam int OUT_LANE_BIT = 0;
    localparam int OUT_CUR_BIT  = 1;
    localparam int OUT_TERM_BIT = 2;
    localparam int OUT_BITS     = 3;
    localparam int PWR_DN_BIT   = 0;

    localparam int SB_PAR  = 0;
    localparam int SB_CS   = 1;
    localparam int SB_SCK  = 2;
    localparam int SB_SDI  = 3;
    localparam int SB_TERM = 4;
    localparam int SYNC_W  = 5;
    localparam logic [SYNC_W-1:0] SYNC_RESET = SYNC_W'(1) << SB_CS;

    typedef struct packed {
        logic one_lane;
        logic low_current;
        logic power_down;
        logic term_en;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic ctrl_t regs_to_ctrl(input logic [OUT_BITS-1:0] out_bits,
                                           input logic pwr_bit);
        ctrl_t c;
        c.one_lane    = out_bits[OUT_LANE_BIT];
        c.low_current = out_bits[OUT_CUR_BIT];
        c.term_en     = out_bits[OUT_TERM_BIT];
        c.power_down  = pwr_bit;
        return c;
    endfunction

    function automatic ctrl_t pins_to_ctrl(input logic cs, input logic sck,
                                           input logic sdi, input logic term);
        ctrl_t c;
        c.one_lane    = cs;
        c.low_current = sck;
        c.power_down  = sdi;
        c.term_en     = term;
        return c;
    endfunction

endpackage

// File: rtl/mode_cfg_sync.sv
module mode_cfg_sync #(
    parameter int                WIDTH     = 5,
    parameter int                STAGES    = 2,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= RESET_VAL;
                    else     stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RESET_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mode_cfg_serial.sv
module mode_cfg_serial
    import mode_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              par_s,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output wr_req_t           wr_o,
    output logic              sdo_pull_low_o
);

    logic                  sck_q;
    logic                  cs_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shift_q;
    logic                  rd_live_q;
    logic [DATA_W-1:0]     rdata_q;

    logic                  active;
    logic                  sck_rise;
    logic                  cs_rise;
    logic                  in_data;
    logic [CMD_BITS-1:0]   cmd_next;

    assign active    = !par_s && !cs_s;
    assign sck_rise  = sck_s && !sck_q;
    assign cs_rise   = cs_s && !cs_q;
    assign cmd_next  = {shift_q[CMD_BITS-2:0], sdi_s};
    assign rd_addr_o = cmd_next[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            cs_q      <= 1'b1;
            cnt_q     <= '0;
            shift_q   <= '0;
            rd_live_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
            if (!active) begin
                cnt_q     <= '0;
                rd_live_q <= 1'b0;
            end else if (sck_rise) begin
                shift_q <= {shift_q[FRAME_BITS-2:0], sdi_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
                    rd_live_q <= cmd_next[CMD_BITS-1];
                    rdata_q   <= rd_data_i;
                end else begin
                    rdata_q <= {rdata_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_comb begin
        wr_o.valid = cs_rise && !par_s && (cnt_q == CNT_W'(FRAME_BITS))
                     && !shift_q[FRAME_BITS-1];
        wr_o.addr  = shift_q[FRAME_BITS-2 -: ADDR_W];
        wr_o.data  = shift_q[DATA_W-1:0];
    end

    assign in_data        = (cnt_q >= CNT_W'(CMD_BITS)) && (cnt_q <= CNT_W'(FRAME_BITS - 1));
    assign sdo_pull_low_o = active && rd_live_q && in_data && !rdata_q[DATA_W-1];

endmodule

// File: rtl/mode_cfg_regfile.sv
module mode_cfg_regfile
    import mode_cfg_pkg::*;
#(
    parameter int NREGS = NUM_REGS
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_req_t             wr_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic [DATA_W-1:0]   aux_o,
    output logic [OUT_BITS-1:0] out_bits_o,
    output logic                pwr_bit_o
);

    logic [DATA_W-1:0] regs_q [NREGS];

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[g] <= '0;
                else if (wr_i.valid && (wr_i.addr == ADDR_W'(g)))
                    regs_q[g] <= wr_i.data;
            end
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = regs_q[i];
        end
    end

    assign aux_o      = regs_q[REG_AUX];
    assign out_bits_o = regs_q[REG_OUT][OUT_BITS-1:0];
    assign pwr_bit_o  = regs_q[REG_PWR][PWR_DN_BIT];

endmodule

// File: rtl/mode_cfg_decode.sv
module mode_cfg_decode
    import mode_cfg_pkg::*;
(
    input  logic                par_s,
    input  logic                cs_s,
    input  logic                sck_s,
    input  logic                sdi_s,
    input  logic                term_s,
    input  logic [OUT_BITS-1:0] out_bits_i,
    input  logic                pwr_bit_i,
    output ctrl_t               ctrl_o
);

    ctrl_t from_regs;
    ctrl_t from_pins;

    assign from_regs = regs_to_ctrl(out_bits_i, pwr_bit_i);
    assign from_pins = pins_to_ctrl(cs_s, sck_s, sdi_s, term_s);
    assign ctrl_o    = par_s ? from_pins : from_regs;

endmodule

// File: rtl/mode_cfg_port.sv
module mode_cfg_port
    import mode_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_par_i,
    input  logic              cs_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              sdo_pad_i,
    output logic              sdo_pull_low_o,
    output logic              one_lane_o,
    output logic              low_current_o,
    output logic              power_down_o,
    output logic              term_en_o,
    output logic [DATA_W-1:0] aux_mode_o
);

    logic [SYNC_W-1:0]   pins_raw;
    logic [SYNC_W-1:0]   pins_s;
    logic                par_s;
    logic                cs_s;
    logic                sck_s;
    logic                sdi_s;
    logic                term_s;
    wr_req_t             wr_req;
    logic [ADDR_W-1:0]   rd_addr;
    logic [DATA_W-1:0]   rd_data;
    logic [OUT_BITS-1:0] out_bits;
    logic                pwr_bit;
    ctrl_t               ctrl;

    always_comb begin
        pins_raw          = '0;
        pins_raw[SB_PAR]  = strap_par_i;
        pins_raw[SB_CS]   = cs_i;
        pins_raw[SB_SCK]  = sck_i;
        pins_raw[SB_SDI]  = sdi_i;
        pins_raw[SB_TERM] = sdo_pad_i;
    end

    mode_cfg_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SYNC_RESET)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_s)
    );

    assign par_s  = pins_s[SB_PAR];
    assign cs_s   = pins_s[SB_CS];
    assign sck_s  = pins_s[SB_SCK];
    assign sdi_s  = pins_s[SB_SDI];
    assign term_s = pins_s[SB_TERM];

    mode_cfg_serial serial_i (
        .clk            (clk),
        .rst            (rst),
        .par_s          (par_s),
        .cs_s           (cs_s),
        .sck_s          (sck_s),
        .sdi_s          (sdi_s),
        .rd_addr_o      (rd_addr),
        .rd_data_i      (rd_data),
        .wr_o           (wr_req),
        .sdo_pull_low_o (sdo_pull_low_o)
    );

    mode_cfg_regfile #(
        .NREGS (NUM_REGS)
    ) regfile_i (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_req),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .aux_o      (aux_mode_o),
        .out_bits_o (out_bits),
        .pwr_bit_o  (pwr_bit)
    );

    mode_cfg_decode decode_i (
        .par_s      (par_s),
        .cs_s       (cs_s),
        .sck_s      (sck_s),
        .sdi_s      (sdi_s),
        .term_s     (term_s),
        .out_bits_i (out_bits),
        .pwr_bit_i  (pwr_bit),
        .ctrl_o     (ctrl)
    );

    assign one_lane_o    = ctrl.one_lane;
    assign low_current_o = ctrl.low_current;
    assign power_down_o  = ctrl.power_down;
    assign term_en_o     = ctrl.term_en;

endmodule

// File: rtl/mode_cfg_port_chk.sv
module mode_cfg_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       par_s,
    input logic       cs_s,
    input logic       wr_valid,
    input logic       sdo_pull_low_o,
    input logic       one_lane_o,
    input logic       low_current_o,
    input logic       power_down_o,
    input logic       term_en_o,
    input logic [7:0] aux_mode_o
);

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        rst |=> (!one_lane_o && !low_current_o && !power_down_o && !term_en_o
                 && aux_mode_o == 8'h00 && !sdo_pull_low_o)); // R1

    AST_STATIC_RELEASED: assert property (@(posedge clk) disable iff (rst)
        par_s |-> !sdo_pull_low_o); // R2

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R3

    AST_AUX_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $changed(aux_mode_o) |-> $past(wr_valid)); // R3

    AST_DRIVE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        sdo_pull_low_o |-> (!cs_s && !par_s)); // R6

    AST_NO_WRITE_STATIC: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !par_s); // R9

endmodule

bind mode_cfg_port mode_cfg_port_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .par_s          (par_s),
    .cs_s           (cs_s),
    .wr_valid       (wr_req.valid),
    .sdo_pull_low_o (sdo_pull_low_o),
    .one_lane_o     (one_lane_o),
    .low_current_o  (low_current_o),
    .power_down_o   (power_down_o),
    .term_en_o      (term_en_o),
    .aux_mode_o     (aux_mode_o)
);

// File: tb/mode_cfg_port_tb_top.sv
module mode_cfg_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_par = 1'b0;
    logic       cs = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo_pad = 1'b0;
    logic       sdo_pull_low;
    logic       one_lane, low_current, power_down, term_en;
    logic [7:0] aux_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] model [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_cfg_port dut_i (
        .clk            (clk),
        .rst            (rst),
        .strap_par_i    (strap_par),
        .cs_i           (cs),
        .sck_i          (sck),
        .sdi_i          (sdi),
        .sdo_pad_i      (sdo_pad),
        .sdo_pull_low_o (sdo_pull_low),
        .one_lane_o     (one_lane),
        .low_current_o  (low_current),
        .power_down_o   (power_down),
        .term_en_o      (term_en),
        .aux_mode_o     (aux_mode)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] expected_outs();
        return {model[0], model[1][2], model[2][0], model[1][1], model[1][0]};
    endfunction

    function automatic logic [11:0] actual_outs();
        return {aux_mode, term_en, power_down, low_current, one_lane};
    endfunction

    // Drives one frame of nedges rising edges; samp[i] is the line level
    // latched just before the falling edge that follows rising edge i+1.
    task automatic frame(input logic [15:0] w, input int nedges, output logic [15:0] samp);
        samp = '1;
        cs = 1'b0;
        idle(HALF);
        for (int i = 0; i < nedges; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            idle(HALF);
            sck = 1'b1;
            idle(HALF);
            if (i < 16) samp[i] = ~sdo_pull_low;
            sck = 1'b0;
        end
        idle(HALF);
        cs = 1'b1;
        idle(4 * HALF);
    endtask

    task automatic write_reg(input logic [6:0] addr, input logic [7:0] data);
        logic [15:0] s;
        frame({1'b0, addr, data}, 16, s);
        if (addr < 7'd3) model[addr] = data;
    endtask

    task automatic read_reg(input string req, input logic [6:0] addr);
        logic [15:0] s;
        logic [7:0]  got;
        logic [7:0]  exp;
        frame({1'b1, addr, 8'h00}, 16, s);
        for (int k = 0; k < 8; k++) got[7-k] = s[7+k];
        exp = (addr < 7'd3) ? model[addr] : 8'h00;
        check({req, " read data"}, {24'd0, got}, {24'd0, exp});
        check({req, " command bits released"}, {24'd0, s[6:0], s[15]}, 32'hFF);
        check({req, " released after frame"}, {31'd0, sdo_pull_low}, 32'd0);
    endtask

    initial begin
        logic [15:0] s;
        for (int i = 0; i < 3; i++) model[i] = 8'h00;
        idle(5);
        rst = 1'b0;
        idle(6);
        // R1 reset state
        check("R1 outputs after reset", {20'd0, actual_outs()}, 32'd0);
        check("R1 sdo released after reset", {31'd0, sdo_pull_low}, 32'd0);

        // R2 static mode sweep over all pin combinations
        strap_par = 1'b1;
        for (int v = 0; v < 16; v++) begin
            cs = v[0]; sck = v[1]; sdi = v[2]; sdo_pad = v[3];
            idle(6);
            check("R2 static pin decode",
                  {28'd0, term_en, power_down, low_current, one_lane}, v);
            check("R2 sdo released in static mode", {31'd0, sdo_pull_low}, 32'd0);
        end
        cs = 1'b1; sck = 1'b0; sdi = 1'b0; sdo_pad = 1'b0;
        idle(4);
        strap_par = 1'b0;
        idle(6);
        check("R9 registers drive outputs after static mode", {20'd0, actual_outs()},
              {20'd0, expected_outs()});

        // R3 R8 R6 sweep of output-control bits with read-back
        for (int v = 0; v < 8; v++) begin
            write_reg(7'd1, 8'(v) | 8'(((v ^ 5) << 5)));
            check("R3 R8 output-control write", {20'd0, actual_outs()}, {20'd0, expected_outs()});
            read_reg("R6 output-control", 7'd1);
        end
        foreach (model[i]) begin end
        write_reg(7'd2, 8'h01);
        check("R8 power-down set", {31'd0, power_down}, 32'd1);
        write_reg(7'd2, 8'hFE);
        check("R8 power-down clear by bit0", {31'd0, power_down}, 32'd0);
        read_reg("R6 power register", 7'd2);

        begin
            logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
            for (int p = 0; p < 6; p++) begin
                write_reg(7'd0, pats[p]);
                check("R3 aux byte write", {24'd0, aux_mode}, {24'd0, pats[p]});
                read_reg("R6 aux byte", 7'd0);
            end
        end

        // R4 wrong frame lengths are discarded
        write_reg(7'd0, 8'h81);
        for (int n = 0; n <= 20; n++) begin
            if (n != 16) begin
                frame({1'b0, 7'd0, 8'h3C}, n, s);
                check($sformatf("R4 frame of %0d edges discarded", n),
                      {20'd0, actual_outs()}, {20'd0, expected_outs()});
            end
        end

        // R5 stray SCK while CS high, then a proper frame
        for (int i = 0; i < 5; i++) begin
            sdi = i[0]; sck = 1'b1; idle(HALF); sck = 1'b0; idle(HALF);
        end
        check("R5 stray clocks change nothing", {20'd0, actual_outs()}, {20'd0, expected_outs()});
        write_reg(7'd0, 8'h6E);
        check("R5 frame after stray clocks commits", {24'd0, aux_mode}, 32'h6E);

        // R7 reads leave state untouched
        write_reg(7'd1, 8'h07);
        read_reg("R7 read of output-control", 7'd1);
        check("R7 outputs unchanged by read", {20'd0, actual_outs()}, {20'd0, expected_outs()});

        // R8 unmapped addresses
        write_reg(7'd5, 8'hFF);
        write_reg(7'h7F, 8'h00);
        check("R8 unmapped writes dropped", {20'd0, actual_outs()}, {20'd0, expected_outs()});
        read_reg("R8 unmapped read", 7'h7F);

        // R9 serial traffic in static mode is ignored
        strap_par = 1'b1;
        idle(6);
        frame({1'b0, 7'd0, 8'h77}, 16, s);
        frame({1'b0, 7'd1, 8'h00}, 16, s);
        check("R9 aux kept in static mode", {24'd0, aux_mode}, {24'd0, model[0]});
        strap_par = 1'b0;
        idle(6);
        check("R9 registers restored after static mode", {20'd0, actual_outs()},
              {20'd0, expected_outs()});
        read_reg("R9 aux after static mode", 7'd0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule